// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time from seconds up to a three-digit year, stored and presented entirely in packed BCD. It counts a reference enable (nominally 32.768 kHz) down to a one-second strobe. On each strobe it advances the time through seconds, minutes, hours, weekday, day of month, month and year. Month lengths and Gregorian leap years are handled. The year field is read as an offset from 1900.

Software or a neighbouring block loads any single field through a small write port: a field select, a data word and a write strobe. The current BCD values are driven continuously on output ports, so an alarm comparator can watch them. The one-second strobe is also brought out. A run enable gates the whole clock. While it is low, time holds, the divider is frozen and writes are refused. Raising it restarts the divider from full count.

Top module: `bcd_calendar_clock`

## Requirements
- R1: While `rtc_en` is 1, `tick_1hz` is a one-cycle pulse that is high in the cycle of every `DIV_COUNT`-th `ref_en` pulse. The time advances by one second at the end of that cycle.
- R2: In the cycle where `rtc_en` rises, the divider reloads and no pulse is produced. The first `tick_1hz` then falls on the `DIV_COUNT`-th `ref_en` pulse after that cycle.
- R3: While `rtc_en` is 0, `tick_1hz` stays 0, all time outputs hold, and the divider position is frozen.
- R4: Seconds wrap from 0x59 to 0x00 with a carry into minutes. Minutes wrap from 0x59 to 0x00 with a carry into hours. Hours wrap from 0x23 to 0x00 and start a new day.
- R5: On a new day, the weekday (0 to 6) increments, and 6 wraps to 0.
- R6: On a new day, the day of month wraps to 0x01 after its last day: 30 for months 0x04, 0x06, 0x09 and 0x11, and 31 for the other months apart from February.
- R7: February has 0x29 days when 1900 + year is divisible by 4 and either not divisible by 100 or divisible by 400. Otherwise it has 0x28 days.
- R8: Months run 0x01 to 0x12. A rollover past 0x12 returns to 0x01 and increments the year. The year wraps from 0x999 to 0x000.
- R9: With `wr_en` = 1 and `rtc_en` = 1, `wr_data` is loaded into the field chosen by `wr_sel`. The codes and the bits taken are:
  - 0: seconds, bits [6:0]
  - 1: minutes, bits [6:0]
  - 2: hours, bits [5:0]
  - 3: weekday, bits [2:0]
  - 4: day of month, bits [5:0]
  - 5: month, bits [4:0]
  - 6: year, bits [11:0], with the hundreds digit in [11:8] and the tens and units in [7:0]
  - Unused upper bits read as 0, and code 7 writes nothing.
- R10: A write with `rtc_en` = 0 is ignored, and every time output is unchanged.
- R11: An accepted write in the same cycle as `tick_1hz` wins. The written field takes the written value, and that second's advance is dropped for every field.
- R12: Reset gives 00:00:00, weekday 0, day 0x01, month 0x01, year 0x000. The divider reloads, and the next rise of `rtc_en` is seen as a new enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference enable, one pulse per reference period |
| rtc_en | input | 1 | Run enable for the clock and write gate |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code |
| wr_data | input | 12 | BCD write data |
| tick_1hz | output | 1 | One-second strobe |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours, BCD |
| wday_bcd | output | 8 | Weekday 0 to 6 |
| mday_bcd | output | 8 | Day of month, BCD |
| mon_bcd | output | 8 | Month 1 to 12, BCD |
| year_bcd | output | 12 | Three-digit BCD year offset from 1900 |

## Verification
The assertions take for granted that every accepted write carries a legal BCD value for its field: a month from 1 to 12, a weekday from 0 to 6, and a day no larger than the length of the current month. The month-range and weekday-wrap properties depend on that. The stimulus only loads such values, and it loads each day of month from a month-length computation of its own. The bench works with a divider count of 4, so many thousands of seconds and every month end of several chosen years can be swept within the run.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

    localparam logic [2:0] SEL_SEC  = 3'd0;
    localparam logic [2:0] SEL_MIN  = 3'd1;
    localparam logic [2:0] SEL_HOUR = 3'd2;
    localparam logic [2:0] SEL_WDAY = 3'd3;
    localparam logic [2:0] SEL_MDAY = 3'd4;
    localparam logic [2:0] SEL_MON  = 3'd5;
    localparam logic [2:0] SEL_YEAR = 3'd6;

    typedef struct packed {
        logic [7:0]  sec;
        logic [7:0]  min;
        logic [7:0]  hour;
        logic [7:0]  wday;
        logic [7:0]  mday;
        logic [7:0]  mon;
        logic [11:0] year;
    } cal_time_t;

    // two-digit BCD increment without wrap
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // three-digit BCD increment, 999 wraps to 000
    function automatic logic [11:0] bcd3_next(input logic [11:0] v);
        logic [11:0] r;
        r = v;
        if (v[3:0] < 4'd9) begin
            r[3:0] = v[3:0] + 4'd1;
        end else begin
            r[3:0] = 4'd0;
            if (v[7:4] < 4'd9) begin
                r[7:4] = v[7:4] + 4'd1;
            end else begin
                r[7:4] = 4'd0;
                r[11:8] = (v[11:8] < 4'd9) ? v[11:8] + 4'd1 : 4'd0;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_sec_divider.sv
`timescale 1ns/1ps
module cal_sec_divider #(
    parameter int DIV_COUNT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_en,
    output logic tick
);
    localparam int CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DIV_COUNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d       = div_q;
        tick        = 1'b0;
        div_d.armed = run;
        if (run && !div_q.armed) begin
            div_d.cnt = LOAD;
        end else if (run && ref_en) begin
            if (div_q.cnt == '0) begin
                tick      = 1'b1;
                div_d.cnt = LOAD;
            end else begin
                div_d.cnt = div_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt   <= LOAD;
            div_q.armed <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/cal_month_days.sv
`timescale 1ns/1ps
module cal_month_days (
    input  logic [7:0]  mon,
    input  logic [11:0] year,
    output logic [7:0]  days
);
    logic [1:0] mod4;
    logic       div4;
    logic       low_zero;
    logic       div400;
    logic       leap;

    always_comb begin
        // 10 = 2 (mod 4) and 100 = 0 (mod 4); 1900 = 0 (mod 4)
        mod4     = year[1:0] + {year[4], 1'b0};
        div4     = (mod4 == 2'd0);
        low_zero = (year[7:0] == 8'h00);
        // 1900 + y divisible by 400 <=> y in {100, 500, 900}
        div400   = low_zero && ((year[11:8] == 4'd1) || (year[11:8] == 4'd5) ||
                                (year[11:8] == 4'd9));
        leap     = div4 && (!low_zero || div400);
        case (mon)
            8'h02:                      days = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: days = 8'h30;
            default:                    days = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int DIV_COUNT = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_en,
    input  logic        rtc_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    output logic        tick_1hz,
    output logic [7:0]  sec_bcd,
    output logic [7:0]  min_bcd,
    output logic [7:0]  hour_bcd,
    output logic [7:0]  wday_bcd,
    output logic [7:0]  mday_bcd,
    output logic [7:0]  mon_bcd,
    output logic [11:0] year_bcd
);
    cal_time_t time_d, time_q;
    logic       tick;
    logic [7:0] month_len;
    logic       wr_ok, adv;
    logic       c_sec, c_min, c_hour, c_day, c_mon;

    cal_sec_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (rtc_en),
        .ref_en (ref_en),
        .tick   (tick)
    );

    cal_month_days u_mdays (
        .mon  (time_q.mon),
        .year (time_q.year),
        .days (month_len)
    );

    always_comb begin
        time_d = time_q;
        wr_ok  = wr_en && rtc_en;
        adv    = tick && !wr_ok;
        c_sec  = (time_q.sec  >= 8'h59);
        c_min  = (time_q.min  >= 8'h59);
        c_hour = (time_q.hour >= 8'h23);
        c_day  = (time_q.mday >= month_len);
        c_mon  = (time_q.mon  >= 8'h12);

        if (adv) begin
            time_d.sec = c_sec ? 8'h00 : bcd_next(time_q.sec);
            if (c_sec) begin
                time_d.min = c_min ? 8'h00 : bcd_next(time_q.min);
                if (c_min) begin
                    time_d.hour = c_hour ? 8'h00 : bcd_next(time_q.hour);
                    if (c_hour) begin
                        time_d.wday = (time_q.wday >= 8'h06) ? 8'h00 : bcd_next(time_q.wday);
                        time_d.mday = c_day ? 8'h01 : bcd_next(time_q.mday);
                        if (c_day) begin
                            time_d.mon = c_mon ? 8'h01 : bcd_next(time_q.mon);
                            if (c_mon) time_d.year = bcd3_next(time_q.year);
                        end
                    end
                end
            end
        end

        if (wr_ok) begin
            case (wr_sel)
                SEL_SEC:  time_d.sec  = {1'b0, wr_data[6:0]};
                SEL_MIN:  time_d.min  = {1'b0, wr_data[6:0]};
                SEL_HOUR: time_d.hour = {2'b0, wr_data[5:0]};
                SEL_WDAY: time_d.wday = {5'b0, wr_data[2:0]};
                SEL_MDAY: time_d.mday = {2'b0, wr_data[5:0]};
                SEL_MON:  time_d.mon  = {3'b0, wr_data[4:0]};
                SEL_YEAR: time_d.year = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q.sec  <= 8'h00;
            time_q.min  <= 8'h00;
            time_q.hour <= 8'h00;
            time_q.wday <= 8'h00;
            time_q.mday <= 8'h01;
            time_q.mon  <= 8'h01;
            time_q.year <= 12'h000;
        end else begin
            time_q <= time_d;
        end
    end

    assign tick_1hz = tick;
    assign sec_bcd  = time_q.sec;
    assign min_bcd  = time_q.min;
    assign hour_bcd = time_q.hour;
    assign wday_bcd = time_q.wday;
    assign mday_bcd = time_q.mday;
    assign mon_bcd  = time_q.mon;
    assign year_bcd = time_q.year;

endmodule

// File: rtl/cal_clock_checker.sv
`timescale 1ns/1ps
module cal_clock_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ref_en,
    input logic        rtc_en,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [11:0] wr_data,
    input logic        tick_1hz,
    input logic [7:0]  sec_bcd,
    input logic [7:0]  min_bcd,
    input logic [7:0]  hour_bcd,
    input logic [7:0]  wday_bcd,
    input logic [7:0]  mday_bcd,
    input logic [7:0]  mon_bcd,
    input logic [11:0] year_bcd
);
    p_tick_needs_ref_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> ref_en);

    p_no_tick_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_en |-> !tick_1hz);

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_en |=> $stable({sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd, year_bcd}));

    p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rtc_en) |=> $stable({sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd, year_bcd}));

    p_min_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !wr_en && sec_bcd != 8'h59) |=> $stable(min_bcd));

    p_wday_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !wr_en && wday_bcd == 8'h06 && hour_bcd == 8'h23 &&
         min_bcd == 8'h59 && sec_bcd == 8'h59) |=> (wday_bcd == 8'h00));

    p_mon_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_bcd != 8'h00) && (mon_bcd <= 8'h12));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rtc_en && wr_sel == 3'd0) |=> (sec_bcd == {1'b0, $past(wr_data[6:0])}));

endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .rtc_en   (rtc_en),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .tick_1hz (tick_1hz),
    .sec_bcd  (sec_bcd),
    .min_bcd  (min_bcd),
    .hour_bcd (hour_bcd),
    .wday_bcd (wday_bcd),
    .mday_bcd (mday_bcd),
    .mon_bcd  (mon_bcd),
    .year_bcd (year_bcd)
);

// File: tb/tb_bcd_calendar_clock.sv
`timescale 1ns/1ps
module tb_bcd_calendar_clock;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en;
    logic        rtc_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [11:0] wr_data = 12'h0;
    logic        tick_1hz;
    logic [7:0]  sec_bcd, min_bcd, hour_bcd, wday_bcd, mday_bcd, mon_bcd;
    logic [11:0] year_bcd;

    int  ref_mode = 0;   // 0 off, 1 every cycle, 2 every other cycle
    logic phase = 1'b0;
    bit  done = 0;
    int  n_run = 0;
    int  n_fail = 0;
    int  m_sec, m_min, m_hr, m_wd, m_md, m_mo, m_yr;

    always #2 clk = ~clk;
    always @(negedge clk) phase <= ~phase;
    assign ref_en = (ref_mode == 1) || (ref_mode == 2 && phase);

    bcd_calendar_clock #(.DIV_COUNT(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rtc_en(rtc_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .tick_1hz(tick_1hz),
        .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd), .wday_bcd(wday_bcd),
        .mday_bcd(mday_bcd), .mon_bcd(mon_bcd), .year_bcd(year_bcd)
    );

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int year_to_bcd(input int y);
        return ((y / 100) << 8) | to_bcd(y % 100);
    endfunction

    function automatic int days_in(input int mo, input int yr);
        int full;
        bit leap;
        full = yr + 1900;
        leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "sec",  int'(sec_bcd),  to_bcd(m_sec));
        chk(req, "min",  int'(min_bcd),  to_bcd(m_min));
        chk(req, "hour", int'(hour_bcd), to_bcd(m_hr));
        chk(req, "wday", int'(wday_bcd), m_wd);
        chk(req, "mday", int'(mday_bcd), to_bcd(m_md));
        chk(req, "mon",  int'(mon_bcd),  to_bcd(m_mo));
        chk(req, "year", int'(year_bcd), year_to_bcd(m_yr));
    endtask

    task automatic model_step();
        m_sec++;
        if (m_sec >= 60) begin
            m_sec = 0; m_min++;
            if (m_min >= 60) begin
                m_min = 0; m_hr++;
                if (m_hr >= 24) begin
                    m_hr = 0;
                    m_wd = (m_wd + 1) % 7;
                    m_md++;
                    if (m_md > days_in(m_mo, m_yr)) begin
                        m_md = 1; m_mo++;
                        if (m_mo > 12) begin
                            m_mo = 1;
                            m_yr = (m_yr + 1) % 1000;
                        end
                    end
                end
            end
        end
    endtask

    // all tasks start and return at a falling edge
    task automatic wr(input int sel, input int data);
        wr_sel  = 3'(sel);
        wr_data = 12'(data);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int wd,
                            input int md, input int mo, input int yr);
        ref_mode = 0;
        wr(0, to_bcd(s));
        wr(1, to_bcd(mi));
        wr(2, to_bcd(h));
        wr(3, wd);
        wr(4, to_bcd(md));
        wr(5, to_bcd(mo));
        wr(6, year_to_bcd(yr));
        ref_mode = 1;
        m_sec = s; m_min = mi; m_hr = h; m_wd = wd; m_md = md; m_mo = mo; m_yr = yr;
    endtask

    task automatic measure(output int n);
        n = 1;
        #1;
        while (!tick_1hz) begin
            @(negedge clk); #1; n++;
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic advance(input int count);
        int n;
        for (int i = 0; i < count; i++) measure(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int ticks;
        int yrs[8] = '{0, 96, 99, 100, 124, 200, 500, 999};
        repeat (3) @(negedge clk);
        // R12: reset state
        m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_md = 1; m_mo = 1; m_yr = 0;
        check_all("R12");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R12");

        // R1: basic advance and period
        rtc_en = 1'b1;
        ref_mode = 1;
        advance(1);
        check_all("R1");
        measure(n);
        chk("R1", "period every cycle", n, DIV);
        ref_mode = 2;
        advance(1);
        measure(n);
        chk("R1", "period alternate", n, 2 * DIV);
        ref_mode = 1;
        advance(1);
        check_all("R1");

        // R3: disable mid-count
        @(negedge clk);
        @(negedge clk);
        rtc_en = 1'b0;
        ticks = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (tick_1hz) ticks++;
        end
        chk("R3", "ticks while disabled", ticks, 0);
        check_all("R3");

        // R10: writes ignored while disabled
        @(negedge clk);
        wr(0, 'h45);
        wr(6, 'h321);
        @(negedge clk);
        check_all("R10");

        // R2: rising enable restarts divider from full count
        rtc_en = 1'b1;
        @(posedge clk);
        n = 0;
        do begin
            @(negedge clk); #1; n++;
        end while (!tick_1hz && n < 100);
        chk("R2", "first tick after enable", n, DIV);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all("R2");

        // R9: field writes and positions
        set_time(12, 34, 5, 3, 17, 8, 124);
        check_all("R9");
        chk("R9", "year raw", int'(year_bcd), 'h124);
        wr(7, 'hFFF);
        check_all("R9");

        // R11: write in strobe cycle wins and drops the advance
        set_time(59, 0, 0, 0, 1, 1, 0);
        #1;
        while (!tick_1hz) begin
            @(negedge clk); #1;
        end
        wr_sel = 3'd0; wr_data = 12'h030; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m_sec = 30;
        check_all("R11");
        chk("R11", "min not advanced", int'(min_bcd), 0);

        // R4: long cascade sweep
        set_time(0, 0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 3700; i++) begin
            advance(1);
            check_all("R4");
        end
        set_time(58, 59, 23, 4, 10, 3, 50);
        advance(3);
        check_all("R4");

        // R5 R6 R7 R8: every month end of chosen years
        foreach (yrs[k]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                set_time(59, 59, 23, 6, days_in(mo, yrs[k]), mo, yrs[k]);
                advance(1);
                if (mo == 2) check_all("R7");
                else if (mo == 12) check_all("R8");
                else check_all("R6");
                chk("R5", "weekday wrap", int'(wday_bcd), 0);
                chk("R6", "day wrapped to 1", int'(mday_bcd), 1);
            end
            set_time(59, 59, 23, 2, 28, 2, yrs[k]);
            advance(1);
            check_all("R7");
        end
        set_time(59, 59, 23, 1, 31, 12, 999);
        advance(1);
        chk("R8", "year wrap", int'(year_bcd), 0);
        check_all("R8");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule